// File: doc/BRIEF.md
# Audio DMA period controller

This block is the register and control slice for one direction of an audio DMA channel. Software configures it through a small memory-mapped register port: a 64-bit ring buffer base, a period layout (how many periods and how many bytes each), a control word carrying run enable, interrupt enables, sample width code and active channel count, and a status word with a period-done flag. The data mover itself is not part of the block; it reports each bus beat through `beat_valid` and `beat_bytes`, and the block tracks the byte offset inside the ring buffer.

Each time the offset crosses a period boundary, the period-done flag is set, and the interrupt line follows that flag gated by its enable. Software clears the flag by writing 1 to it. The byte counter wraps to the start of the ring when it reaches the full buffer size. Clearing the run enable freezes the counter, and setting it again resumes from where it stopped.

A soft reset is requested by writing the reset bit of the control word. It is sequenced by a three-state machine. `RST_IDLE` goes to `RST_FLUSH` on a reset request. `RST_FLUSH` counts and goes to `RST_CLEAR` in its last counted cycle. `RST_CLEAR` returns to `RST_IDLE` after one cycle. The reset bit reads 1 while the machine is outside `RST_IDLE`, so software can poll it until it drops.

Top module: `aud_period_ctrl`

## Requirements
- R1: After `rst_n` is released, control (0x10) reads 0, status (0x14) reads 0, the byte count (0x28) reads 0, period config (0x1C) reads 0x0002_00C0 (2 periods of 192 bytes), and `irq_period` is 0.
- R2: A control write with bit 1 set starts a soft reset. Bit 1 of control reads 1 for exactly 8 cycles after the write edge and 0 after that. The other bits of that write are not applied.
- R3: Soft reset clears run enable (bit 0), the period interrupt enable (bit 13), the timeout enable (bit 14), the status flag and the byte count. The base address, period config, width code and channel count keep their values.
- R4: While run enable is 1, each cycle with `beat_valid` adds `beat_bytes` (at most 64) to the byte count. While run enable is 0, beats leave the count unchanged. Setting enable again continues from the held count.
- R5: When the byte count reaches periods × period bytes, it wraps and restarts at the excess, which is 0 for aligned beats.
- R6: Status bit 31 becomes 1 on the clock edge at which a beat completes a period. Writing 1 to bit 31 clears it, and writing 0 leaves it unchanged.
- R7: If a period completes in the same cycle as a write of 1 to status bit 31, the flag ends up set.
- R8: `irq_period` is 1 exactly when status bit 31 and control bit 13 are both 1.
- R9: A period config write (count in bits [31:16], bytes in bits [15:0]) is accepted only if the count is in 2..6 and the bytes are in 192..51200 and a multiple of 64. It is also ignored while run enable is 1. A rejected write leaves the register unchanged.
- R10: Control bits [18:16] hold the sample width code (0=8, 1=16, 2=20, 3=24, 4=32 bits). A write carrying code 5..7 leaves the field unchanged but still updates the other fields. Bits [22:19] hold the active channel count. Bit 14 is stored when the direction is capture.
- R11: Base low (0x20) and base high (0x24) read back as written and appear on `buf_base` as {high, low}.
- R12: While soft reset is in progress, beats do not move the count and control writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| beat_valid | input | 1 | Data mover moved one beat this cycle |
| beat_bytes | input | 7 | Bytes moved by that beat |
| dma_active | output | 1 | Run enable set and no soft reset in progress |
| buf_base | output | 64 | Ring buffer base address |
| irq_period | output | 1 | Level period interrupt |

## Verification
Register reads are combinational, and every register update lands on the edge that samples the write or beat. The bench therefore drives at a falling edge and reads back at the next falling edge, one cycle later, for writes, beats, status set and interrupt. The soft reset bit is sampled at each falling edge after the request: it must be 1 at falling edges 1 to 8 and 0 at falling edge 9. The collision case drives a period-completing beat and the clearing write in the same cycle and reads status one cycle later.

// File: rtl/aud_period_pkg.sv
package aud_period_pkg;

    localparam logic [7:0] OFF_CTRL    = 8'h10;
    localparam logic [7:0] OFF_STAT    = 8'h14;
    localparam logic [7:0] OFF_PCFG    = 8'h1C;
    localparam logic [7:0] OFF_BASE_LO = 8'h20;
    localparam logic [7:0] OFF_BASE_HI = 8'h24;
    localparam logic [7:0] OFF_XCNT    = 8'h28;

    localparam int B_EN        = 0;
    localparam int B_RST       = 1;
    localparam int B_IOC_IE    = 13;
    localparam int B_TOUT_IE   = 14;
    localparam int B_WIDTH_LO  = 16;
    localparam int WIDTH_W     = 3;
    localparam int B_CH_LO     = 19;
    localparam int B_STAT_DONE = 31;
    localparam int PCFG_CNT_LO = 16;

    localparam logic [2:0] WCODE_MAX = 3'd4;

    typedef enum logic [1:0] {
        RST_IDLE,
        RST_FLUSH,
        RST_CLEAR
    } rst_state_e;

endpackage

// File: rtl/aud_soft_reset_fsm.sv
module aud_soft_reset_fsm
    import aud_period_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy
);
    localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_FLUSH = CNT_W'(RST_CYCLES - 2);

    rst_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE:  if (req) state_d = RST_FLUSH;
            RST_FLUSH: if (cnt_q == LAST_FLUSH) state_d = RST_CLEAR;
            RST_CLEAR: state_d = RST_IDLE;
            default:   state_d = RST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RST_FLUSH) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    always_comb begin
        busy = (state_q != RST_IDLE);
    end

    // checker: busy window length
    logic [7:0] chk_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    chk_len <= '0;
        else if (busy) chk_len <= chk_len + 1'b1;
        else           chk_len <= '0;
    end

    a_r2_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_len == 8'(RST_CYCLES)));

endmodule

// File: rtl/aud_ring_tracker.sv
module aud_ring_tracker #(
    parameter int CNT_W   = 32,
    parameter int BYTES_W = 16,
    parameter int PER_W   = 16,
    parameter int BEAT_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               beat_valid,
    input  logic [BEAT_W-1:0]  beat_bytes,
    input  logic [BYTES_W-1:0] period_bytes,
    input  logic [PER_W-1:0]   period_count,
    output logic [CNT_W-1:0]   xfer_count,
    output logic               period_hit
);
    localparam int OFF_W = BYTES_W + 1;

    logic [CNT_W-1:0] buf_size;
    logic [CNT_W-1:0] cnt_sum, cnt_nxt;
    logic [OFF_W-1:0] off_q, off_sum, off_nxt, pbytes_ext;
    logic             crossing, step;

    assign buf_size   = CNT_W'(period_bytes) * CNT_W'(period_count);
    assign pbytes_ext = {1'b0, period_bytes};
    assign step       = run && beat_valid && !clr;

    always_comb begin
        off_sum  = off_q + OFF_W'(beat_bytes);
        crossing = (off_sum >= pbytes_ext);
        off_nxt  = crossing ? (off_sum - pbytes_ext) : off_sum;
        cnt_sum  = xfer_count + CNT_W'(beat_bytes);
        cnt_nxt  = (cnt_sum >= buf_size) ? (cnt_sum - buf_size) : cnt_sum;
    end

    assign period_hit = step && crossing;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_count <= '0;
            off_q      <= '0;
        end else if (clr) begin
            xfer_count <= '0;
            off_q      <= '0;
        end else if (step) begin
            xfer_count <= cnt_nxt;
            off_q      <= off_nxt;
        end
    end

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(run && beat_valid)) |=> $stable(xfer_count));

    a_r5_stays_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (xfer_count < buf_size)) |=> (xfer_count < buf_size));

    a_r12_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (xfer_count == '0));

endmodule

// File: rtl/aud_ctrl_regs.sv
module aud_ctrl_regs
    import aud_period_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int BYTES_W     = 16,
    parameter int PER_W       = 16,
    parameter int CH_W        = 4,
    parameter bit IS_CAPTURE  = 1'b1,
    parameter int MIN_PERIODS = 2,
    parameter int MAX_PERIODS = 6,
    parameter int MIN_PBYTES  = 192,
    parameter int MAX_PBYTES  = 51200,
    parameter int PBYTE_STEP  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               busy,
    input  logic               reg_wr,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic [CNT_W-1:0]   xfer_count,
    input  logic               period_hit,
    output logic [31:0]        reg_rdata,
    output logic               rst_req,
    output logic               en,
    output logic [BYTES_W-1:0] period_bytes,
    output logic [PER_W-1:0]   period_count,
    output logic [63:0]        buf_base,
    output logic               irq
);
    logic               en_q, ioc_ie_q, tout_ie_q, status_q;
    logic [WIDTH_W-1:0] width_q;
    logic [CH_W-1:0]    ch_q;
    logic [BYTES_W-1:0] pbytes_q;
    logic [PER_W-1:0]   pcnt_q;
    logic [31:0]        base_lo_q, base_hi_q;

    logic wr_ctrl, wr_stat, wr_pcfg, ctrl_take, stat_w1c, pcfg_ok, wipe;
    logic [WIDTH_W-1:0] w_code;
    logic [PER_W-1:0]   w_cnt;
    logic [BYTES_W-1:0] w_bytes;

    assign wr_ctrl   = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == OFF_STAT);
    assign wr_pcfg   = reg_wr && (reg_addr == OFF_PCFG);
    assign rst_req   = wr_ctrl && reg_wdata[B_RST] && !busy;
    assign ctrl_take = wr_ctrl && !reg_wdata[B_RST] && !busy;
    assign stat_w1c  = wr_stat && reg_wdata[B_STAT_DONE];
    assign wipe      = busy || rst_req;

    assign w_code  = reg_wdata[B_WIDTH_LO +: WIDTH_W];
    assign w_cnt   = reg_wdata[PCFG_CNT_LO +: PER_W];
    assign w_bytes = reg_wdata[BYTES_W-1:0];

    always_comb begin
        pcfg_ok = (int'(w_cnt) >= MIN_PERIODS) && (int'(w_cnt) <= MAX_PERIODS) &&
                  (int'(w_bytes) >= MIN_PBYTES) && (int'(w_bytes) <= MAX_PBYTES) &&
                  ((int'(w_bytes) % PBYTE_STEP) == 0);
    end

    // control word: clears on soft reset, fields kept otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            ioc_ie_q <= 1'b0;
            width_q  <= '0;
            ch_q     <= '0;
        end else if (wipe) begin
            en_q     <= 1'b0;
            ioc_ie_q <= 1'b0;
        end else if (ctrl_take) begin
            en_q     <= reg_wdata[B_EN];
            ioc_ie_q <= reg_wdata[B_IOC_IE];
            ch_q     <= reg_wdata[B_CH_LO +: CH_W];
            if (w_code <= WCODE_MAX) width_q <= w_code;
        end
    end

    generate
        if (IS_CAPTURE) begin : g_tout
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         tout_ie_q <= 1'b0;
                else if (wipe)      tout_ie_q <= 1'b0;
                else if (ctrl_take) tout_ie_q <= reg_wdata[B_TOUT_IE];
            end
        end else begin : g_no_tout
            assign tout_ie_q = 1'b0;
        end
    endgenerate

    // period-done flag: set beats write-1-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (wipe)       status_q <= 1'b0;
        else if (period_hit) status_q <= 1'b1;
        else if (stat_w1c)   status_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pbytes_q <= BYTES_W'(MIN_PBYTES);
            pcnt_q   <= PER_W'(MIN_PERIODS);
        end else if (wr_pcfg && pcfg_ok && !en_q) begin
            pbytes_q <= w_bytes;
            pcnt_q   <= w_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFF_BASE_LO) base_lo_q <= reg_wdata;
            if (reg_addr == OFF_BASE_HI) base_hi_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[B_EN]                   = en_q;
                reg_rdata[B_RST]                  = busy;
                reg_rdata[B_IOC_IE]               = ioc_ie_q;
                reg_rdata[B_TOUT_IE]              = tout_ie_q;
                reg_rdata[B_WIDTH_LO +: WIDTH_W]  = width_q;
                reg_rdata[B_CH_LO +: CH_W]        = ch_q;
            end
            OFF_STAT:    reg_rdata[B_STAT_DONE] = status_q;
            OFF_PCFG: begin
                reg_rdata[PCFG_CNT_LO +: PER_W] = pcnt_q;
                reg_rdata[BYTES_W-1:0]          = pbytes_q;
            end
            OFF_BASE_LO: reg_rdata = base_lo_q;
            OFF_BASE_HI: reg_rdata = base_hi_q;
            OFF_XCNT:    reg_rdata = 32'(xfer_count);
            default:     reg_rdata = '0;
        endcase
    end

    assign en           = en_q;
    assign period_bytes = pbytes_q;
    assign period_count = pcnt_q;
    assign buf_base     = {base_hi_q, base_lo_q};
    assign irq          = status_q && ioc_ie_q;

    a_r3_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!en_q && !status_q && !ioc_ie_q));

    a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (period_hit && !rst_req) |=> status_q);

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_w1c && !period_hit) |=> !status_q);

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(pbytes_q) && $stable(pcnt_q)));

    a_r10_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= WCODE_MAX);

endmodule

// File: rtl/aud_period_ctrl.sv
module aud_period_ctrl #(
    parameter int CH_W        = 4,
    parameter int BEAT_W      = 7,
    parameter int RST_CYCLES  = 8,
    parameter bit IS_CAPTURE  = 1'b1,
    parameter int MIN_PERIODS = 2,
    parameter int MAX_PERIODS = 6,
    parameter int MIN_PBYTES  = 192,
    parameter int MAX_PBYTES  = 51200,
    parameter int PBYTE_STEP  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              beat_valid,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              dma_active,
    output logic [63:0]       buf_base,
    output logic              irq_period
);
    localparam int CNT_W   = 32;
    localparam int BYTES_W = 16;
    localparam int PER_W   = 16;

    logic               busy, rst_req, en, period_hit;
    logic [BYTES_W-1:0] period_bytes;
    logic [PER_W-1:0]   period_count;
    logic [CNT_W-1:0]   xfer_count;

    aud_soft_reset_fsm #(
        .RST_CYCLES (RST_CYCLES)
    ) u_rst_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rst_req),
        .busy  (busy)
    );

    aud_ring_tracker #(
        .CNT_W   (CNT_W),
        .BYTES_W (BYTES_W),
        .PER_W   (PER_W),
        .BEAT_W  (BEAT_W)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (busy || rst_req),
        .run          (en),
        .beat_valid   (beat_valid),
        .beat_bytes   (beat_bytes),
        .period_bytes (period_bytes),
        .period_count (period_count),
        .xfer_count   (xfer_count),
        .period_hit   (period_hit)
    );

    aud_ctrl_regs #(
        .CNT_W       (CNT_W),
        .BYTES_W     (BYTES_W),
        .PER_W       (PER_W),
        .CH_W        (CH_W),
        .IS_CAPTURE  (IS_CAPTURE),
        .MIN_PERIODS (MIN_PERIODS),
        .MAX_PERIODS (MAX_PERIODS),
        .MIN_PBYTES  (MIN_PBYTES),
        .MAX_PBYTES  (MAX_PBYTES),
        .PBYTE_STEP  (PBYTE_STEP)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy         (busy),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .xfer_count   (xfer_count),
        .period_hit   (period_hit),
        .reg_rdata    (reg_rdata),
        .rst_req      (rst_req),
        .en           (en),
        .period_bytes (period_bytes),
        .period_count (period_count),
        .buf_base     (buf_base),
        .irq          (irq_period)
    );

    assign dma_active = en && !busy;

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_period |-> !busy);

endmodule

// File: tb/aud_period_ctrl_bench.sv
module aud_period_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        beat_valid = 1'b0;
    logic [6:0]  beat_bytes = '0;
    logic        dma_active;
    logic [63:0] buf_base;
    logic        irq_period;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [7:0] A_CTRL = 8'h10, A_STAT = 8'h14, A_PCFG = 8'h1C,
                           A_LO = 8'h20, A_HI = 8'h24, A_CNT = 8'h28;

    always #5 clk = ~clk;

    aud_period_ctrl u_aud_period_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .beat_valid (beat_valid),
        .beat_bytes (beat_bytes),
        .dma_active (dma_active),
        .buf_base   (buf_base),
        .irq_period (irq_period)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic beat(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            beat_valid = 1'b1; beat_bytes = 7'd64;
            @(posedge clk); #1;
            beat_valid = 1'b0;
        end
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        rd(A_CNT, d);  chk("R1 count", d, 32'h0);
        rd(A_PCFG, d); chk("R1 pcfg", d, 32'h0002_00C0);
        chk("R1 irq", irq_period, 1'b0);
    endtask

    task automatic t_base;
        logic [31:0] d;
        wr(A_LO, 32'hDEAD_BEEF);
        wr(A_HI, 32'h1234_5678);
        rd(A_LO, d); chk("R11 base lo", d, 32'hDEAD_BEEF);
        rd(A_HI, d); chk("R11 base hi", d, 32'h1234_5678);
        chk("R11 buf_base", buf_base, 64'h1234_5678_DEAD_BEEF);
    endtask

    task automatic t_pcfg;
        logic [31:0] d;
        wr(A_PCFG, 32'h0007_00C0);
        rd(A_PCFG, d); chk("R9 too many periods", d, 32'h0002_00C0);
        wr(A_PCFG, 32'h0002_00C8);
        rd(A_PCFG, d); chk("R9 not multiple of 64", d, 32'h0002_00C0);
        wr(A_PCFG, 32'h0002_0080);
        rd(A_PCFG, d); chk("R9 below 192", d, 32'h0002_00C0);
        wr(A_PCFG, 32'h0003_0100);
        rd(A_PCFG, d); chk("R9 valid accepted", d, 32'h0003_0100);
    endtask

    task automatic t_ctrl_fields;
        logic [31:0] d;
        wr(A_CTRL, 32'h0013_6000);
        rd(A_CTRL, d); chk("R10 fields stored", d, 32'h0013_6000);
        wr(A_CTRL, 32'h0015_6000);
        rd(A_CTRL, d); chk("R10 illegal width kept", d, 32'h0013_6000);
        wr(A_CTRL, 32'h0023_6000);
        rd(A_CTRL, d); chk("R10 channels updated", d, 32'h0023_6000);
        wr(A_CTRL, 32'h0013_6000);
    endtask

    task automatic t_run;
        logic [31:0] d;
        wr(A_CTRL, 32'h0013_6001);
        chk("R4 dma_active", dma_active, 1'b1);
        beat(3);
        rd(A_CNT, d);  chk("R4 count 192", d, 32'd192);
        rd(A_STAT, d); chk("R6 no flag mid period", d, 32'h0);
        beat(1);
        rd(A_CNT, d);  chk("R4 count 256", d, 32'd256);
        rd(A_STAT, d); chk("R6 flag at boundary", d, 32'h8000_0000);
        chk("R8 irq on", irq_period, 1'b1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R6 write 0 no effect", d, 32'h8000_0000);
        wr(A_CTRL, 32'h0013_4001);
        chk("R8 irq masked", irq_period, 1'b0);
        wr(A_CTRL, 32'h0013_6001);
        chk("R8 irq unmasked", irq_period, 1'b1);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, d); chk("R6 w1c", d, 32'h0);
        chk("R8 irq off after clear", irq_period, 1'b0);
        wr(A_PCFG, 32'h0002_0100);
        rd(A_PCFG, d); chk("R9 ignored while enabled", d, 32'h0003_0100);
        wr(A_CTRL, 32'h0013_6000);
        beat(2);
        rd(A_CNT, d);  chk("R4 paused count frozen", d, 32'd256);
        wr(A_CTRL, 32'h0013_6001);
        beat(4);
        rd(A_CNT, d);  chk("R4 resumed count", d, 32'd512);
        beat(3);
        rd(A_CNT, d);  chk("R4 count 704", d, 32'd704);
        // R7: period-completing beat and clear in one cycle
        @(negedge clk);
        beat_valid = 1'b1; beat_bytes = 7'd64;
        reg_addr = A_STAT; reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
        @(posedge clk); #1;
        beat_valid = 1'b0; reg_wr = 1'b0;
        rd(A_STAT, d); chk("R7 set wins", d, 32'h8000_0000);
        rd(A_CNT, d);  chk("R5 wrap to zero", d, 32'd0);
        wr(A_STAT, 32'h8000_0000);
        rd(A_STAT, d); chk("R6 clear after collision", d, 32'h0);
    endtask

    task automatic t_soft_reset;
        logic [31:0] d;
        beat(4);
        rd(A_STAT, d); chk("R6 flag before reset", d, 32'h8000_0000);
        wr(A_CTRL, 32'h0013_6003);
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            reg_addr = A_CTRL; reg_wdata = 32'h0000_2001;
            reg_wr = (k == 3); beat_valid = 1'b1; beat_bytes = 7'd64;
            #1;
            chk($sformatf("R2 busy bit k=%0d", k), reg_rdata[1], (k <= 8));
        end
        @(negedge clk);
        reg_wr = 1'b0; beat_valid = 1'b0;
        rd(A_CTRL, d); chk("R3 R12 ctrl after reset", d, 32'h0013_0000);
        rd(A_CNT, d);  chk("R3 R12 count cleared", d, 32'd0);
        rd(A_STAT, d); chk("R3 status cleared", d, 32'h0);
        rd(A_PCFG, d); chk("R3 pcfg kept", d, 32'h0003_0100);
        rd(A_LO, d);   chk("R3 base kept", d, 32'hDEAD_BEEF);
        chk("R3 irq low", irq_period, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_base();
        t_pcfg();
        t_ctrl_fields();
        t_run();
        t_soft_reset();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule